// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a host register interface and the byte engine of an SPI controller. It buffers bytes in both directions, with one eight-entry first-in first-out store for bytes waiting to be sent and one for bytes that have arrived. From the two fill levels and a few engine events it derives a 32-bit status word. It merges that word with the enable bits of a control word into a single registered interrupt request.

The host pushes transmit bytes and pops receive bytes through dedicated strobes. It reads and writes the control and status words through a one-bit-address register port. The engine draws transmit bytes with a take strobe, delivers received bytes with a valid strobe, and pulses a done strobe when a byte has finished shifting. The transmit halfway flag is sticky. It latches when the transmit level arrives at four and stays set as the level drains, until the host pushes another byte. The overrun error and overrun warning flags share one interrupt enable.

Top module: `spi_fifo_stat`

## Requirements
- R1: After reset the status word reads 0x0000_0120, the control word reads 0x0000_0001 (FIFO mode on, every enable off) and irq_o is 0.
- R2: Each queue holds 8 bytes and returns them in arrival order. A host push into a full transmit queue is dropped. A pop or take on an empty queue is ignored. eng_tx_req_o is 1 exactly when the transmit queue is non-empty, and eng_tx_data_o and rx_data_o show the oldest entry of their queue.
- R3: Status bit 10 (transmit full) is 1 while the transmit queue holds 8 bytes. It drops as soon as a take moves a byte to the engine.
- R4: Status bit 9 (transmit halfway) sets in the cycle the transmit level becomes exactly 4 from another level. It stays set as the level falls below 4. It clears only when an accepted host push leaves the level at a value other than a fresh arrival at 4.
- R5: Status bit 8 is transmit empty, bit 7 receive full (8 bytes), bit 6 receive halfway (4 or more bytes) and bit 5 receive empty.
- R6: Status bit 4 (overrun error) sets when eng_rx_valid_i arrives while the receive queue is full. That byte is discarded.
- R7: Status bit 3 (overrun warning) sets in the cycle the receive level becomes 8.
- R8: A write to the status word (address 1) clears bits 4, 3 and 0 wherever the written bit is 0, leaves them unchanged where it is 1, and a set in the same cycle wins. Other status bits are not writable.
- R9: Status bit 0 (transmit complete) sets when eng_done_i pulses while the transmit queue is empty.
- R10: The control word (address 0, bits 7:0) holds: bit 0 FIFO mode, bit 1 overrun enable, bit 2 transmit-complete enable, bit 3 receive-halfway enable, bit 4 receive-full enable, bit 5 transmit-empty enable, bit 6 transmit-halfway enable, bit 7 receive-not-empty enable. The interrupt is the OR of every set flag ANDed with its enable, and bit 1 covers both overrun flags.
- R11: irq_o is registered and reflects the flags and enables of the previous cycle.
- R12: With FIFO mode off, status bits 10 to 5 read 0 and their interrupt terms (receive halfway, receive full, transmit empty, transmit halfway, receive not empty) are masked. Bits 4, 3 and 0 are unaffected. Unused bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| tx_push_i | input | 1 | Host pushes a transmit byte |
| tx_data_i | input | 8 | Transmit byte from host |
| rx_pop_i | input | 1 | Host pops the oldest received byte |
| rx_data_o | output | 8 | Oldest received byte |
| eng_tx_req_o | output | 1 | A transmit byte is available to the engine |
| eng_tx_data_o | output | 8 | Oldest transmit byte |
| eng_tx_take_i | input | 1 | Engine takes the oldest transmit byte |
| eng_rx_valid_i | input | 1 | Engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte from the engine |
| eng_done_i | input | 1 | Engine finished shifting a byte |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The embedded properties watch several behaviours on every cycle. The queue levels never exceed eight. A push into a full queue and a pop from an empty one leave the level alone. The halfway latch sets on arrival at four and holds until a push. Overrun and warning latch on their trigger, and an event set wins over a clearing write. With FIFO mode and the two unmaskable enables off, the interrupt stays low. Byte ordering, the exact status word under each fill level, the write-one-keeps behaviour and the one-cycle interrupt lag can be shown only by the bench's scenarios, which compare against a queue-based model.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  // status word bit positions
  localparam int ST_TXC  = 0;
  localparam int ST_OW   = 3;
  localparam int ST_OE   = 4;
  localparam int ST_RXEM = 5;
  localparam int ST_RXHA = 6;
  localparam int ST_RXFU = 7;
  localparam int ST_TXEM = 8;
  localparam int ST_TXHA = 9;
  localparam int ST_TXFU = 10;

  // control word bit positions
  localparam int CT_MODE    = 0;
  localparam int CT_IE_OVR  = 1;
  localparam int CT_IE_TXC  = 2;
  localparam int CT_IE_RXHA = 3;
  localparam int CT_IE_RXFU = 4;
  localparam int CT_IE_TXEM = 5;
  localparam int CT_IE_TXHA = 6;
  localparam int CT_IE_RXNE = 7;
  localparam int CTRL_W     = 8;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h01;

  // write-zero-to-clear event flags
  localparam int EV_TXC = 0;
  localparam int EV_OW  = 1;
  localparam int EV_OE  = 2;
  localparam int EV_N   = 3;

  localparam int TERM_N = 7;

  typedef enum logic {
    A_CTRL = 1'b0,
    A_STAT = 1'b1
  } reg_sel_e;

  function automatic int ev_pos(input int idx);
    case (idx)
      EV_TXC:  return ST_TXC;
      EV_OW:   return ST_OW;
      default: return ST_OE;
    endcase
  endfunction

endpackage

// File: rtl/sfs_rst_sync.sv
module sfs_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  always_comb begin
    rd_d  = pop_ok  ? ptr_inc(rd_q) : rd_q;
    wr_d  = push_ok ? ptr_inc(wr_q) : wr_q;
    cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  assign head_o    = mem_q[rd_q];
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  // R2: level bounded by depth
  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R2: push into a full queue is dropped
  a_r2_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (cnt_q == CW'(DEPTH)));
  // R2: pop from an empty queue is ignored
  a_r2_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (cnt_q == '0));
endmodule

// File: rtl/sfs_evflag.sv
module sfs_evflag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wclr_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    if (set_i)       q_d = 1'b1;
    else if (wclr_i) q_d = 1'b0;
    else             q_d = q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R8: a set in the same cycle as a clearing write wins
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
endmodule

// File: rtl/sfs_irq.sv
module sfs_irq #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] terms_i,
  output logic         irq_o
);
  logic irq_q, irq_d;

  assign irq_d = |terms_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
  import sfs_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 8,
  parameter  int REG_W  = 32,
  localparam int CW     = $clog2(DEPTH) + 1,
  localparam int HALF   = DEPTH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              eng_tx_req_o,
  output logic [DATA_W-1:0] eng_tx_data_o,
  input  logic              eng_tx_take_i,
  input  logic              eng_rx_valid_i,
  input  logic [DATA_W-1:0] eng_rx_data_i,
  input  logic              eng_done_i,
  output logic              irq_o
);
  logic              rst_n;
  logic [CW-1:0]     tx_cnt, tx_cnt_nxt, rx_cnt, rx_cnt_nxt;
  logic              tx_full, tx_empty, rx_full, rx_empty, rx_half;
  logic              tx_push_ok;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              txha_q, txha_d, txha_reach;
  logic              ctrl_wr, stat_wr, mode;
  logic [EV_N-1:0]   ev_set, ev_q;
  logic [TERM_N-1:0] terms;
  logic [REG_W-1:0]  stat;

  sfs_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  sfs_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .push_i    (tx_push_i),
    .wdata_i   (tx_data_i),
    .pop_i     (eng_tx_take_i),
    .head_o    (eng_tx_data_o),
    .cnt_o     (tx_cnt),
    .cnt_nxt_o (tx_cnt_nxt),
    .full_o    (tx_full),
    .empty_o   (tx_empty)
  );

  sfs_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .push_i    (eng_rx_valid_i),
    .wdata_i   (eng_rx_data_i),
    .pop_i     (rx_pop_i),
    .head_o    (rx_data_o),
    .cnt_o     (rx_cnt),
    .cnt_nxt_o (rx_cnt_nxt),
    .full_o    (rx_full),
    .empty_o   (rx_empty)
  );

  assign eng_tx_req_o = !tx_empty;
  assign rx_half      = (rx_cnt >= CW'(HALF));
  assign tx_push_ok   = tx_push_i && !tx_full;
  assign ctrl_wr      = reg_wr_i && (reg_sel_e'(reg_addr_i) == A_CTRL);
  assign stat_wr      = reg_wr_i && (reg_sel_e'(reg_addr_i) == A_STAT);
  assign mode         = ctrl_q[CT_MODE];

  // control register
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = reg_wdata_i[CTRL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  // sticky transmit halfway latch
  assign txha_reach = (tx_cnt_nxt == CW'(HALF)) && (tx_cnt != CW'(HALF));

  always_comb begin
    if (txha_reach)      txha_d = 1'b1;
    else if (tx_push_ok) txha_d = 1'b0;
    else                 txha_d = txha_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) txha_q <= 1'b0;
    else        txha_q <= txha_d;
  end

  // write-zero-to-clear event flags
  always_comb begin
    ev_set         = '0;
    ev_set[EV_TXC] = eng_done_i && tx_empty;
    ev_set[EV_OW]  = (rx_cnt_nxt == CW'(DEPTH)) && !rx_full;
    ev_set[EV_OE]  = eng_rx_valid_i && rx_full;
  end

  for (genvar gi = 0; gi < EV_N; gi++) begin : g_ev
    sfs_evflag u_ev (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .set_i  (ev_set[gi]),
      .wclr_i (stat_wr && !reg_wdata_i[ev_pos(gi)]),
      .q_o    (ev_q[gi])
    );
  end

  // status word
  always_comb begin
    stat = '0;
    if (mode) begin
      stat[ST_TXFU] = tx_full;
      stat[ST_TXHA] = txha_q;
      stat[ST_TXEM] = tx_empty;
      stat[ST_RXFU] = rx_full;
      stat[ST_RXHA] = rx_half;
      stat[ST_RXEM] = rx_empty;
    end
    stat[ST_OE]  = ev_q[EV_OE];
    stat[ST_OW]  = ev_q[EV_OW];
    stat[ST_TXC] = ev_q[EV_TXC];
  end

  assign reg_rdata_o = (reg_sel_e'(reg_addr_i) == A_CTRL) ? REG_W'(ctrl_q) : stat;

  // interrupt terms
  always_comb begin
    terms    = '0;
    terms[0] = ctrl_q[CT_IE_OVR] && (ev_q[EV_OE] || ev_q[EV_OW]);
    terms[1] = ctrl_q[CT_IE_TXC] && ev_q[EV_TXC];
    terms[2] = mode && ctrl_q[CT_IE_RXHA] && rx_half;
    terms[3] = mode && ctrl_q[CT_IE_RXFU] && rx_full;
    terms[4] = mode && ctrl_q[CT_IE_TXEM] && tx_empty;
    terms[5] = mode && ctrl_q[CT_IE_TXHA] && txha_q;
    terms[6] = mode && ctrl_q[CT_IE_RXNE] && !rx_empty;
  end

  sfs_irq #(.N(TERM_N)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .terms_i (terms),
    .irq_o   (irq_o)
  );

  // R4: latch sets when the level arrives at half
  a_r4_txha_on_reach: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((tx_cnt_nxt == CW'(HALF)) && (tx_cnt != CW'(HALF))) |=> txha_q);
  // R4: latch holds without an accepted push
  a_r4_txha_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (txha_q && !(tx_push_i && !tx_full)) |=> txha_q);
  // R6: arrival into a full receive queue flags overrun
  a_r6_overrun: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rx_full && eng_rx_valid_i) |=> reg_sel_e'(1'b1) == A_STAT && ev_q[EV_OE]);
  // R7: warning on reaching full
  a_r7_warn: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((rx_cnt_nxt == CW'(DEPTH)) && !rx_full) |=> ev_q[EV_OW]);
  // R12: mode off and unmaskable enables off keep the request low
  a_r12_mode_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ctrl_q[CT_MODE] && !ctrl_q[CT_IE_OVR] && !ctrl_q[CT_IE_TXC]) |=> !irq_o);
endmodule

// File: tb/sim_spi_fifo_stat.sv
module sim_spi_fifo_stat;
  logic        clk, rst_n;
  logic        reg_wr, reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        tx_push, rx_pop, eng_tx_req, eng_tx_take, eng_rx_valid, eng_done, irq;
  logic [7:0]  tx_data, rx_data, eng_tx_data, eng_rx_data;

  int total, fails;
  bit checking, finished;

  logic [7:0] tq[$];
  logic [7:0] rq[$];
  bit         m_txha, m_oe, m_ow, m_txc, m_irq;
  logic [7:0] m_ctrl;

  spi_fifo_stat u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_push_i(tx_push), .tx_data_i(tx_data),
    .rx_pop_i(rx_pop), .rx_data_o(rx_data),
    .eng_tx_req_o(eng_tx_req), .eng_tx_data_o(eng_tx_data), .eng_tx_take_i(eng_tx_take),
    .eng_rx_valid_i(eng_rx_valid), .eng_rx_data_i(eng_rx_data), .eng_done_i(eng_done),
    .irq_o(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_exp();
    logic [31:0] s = '0;
    if (m_ctrl[0]) begin
      s[10] = (tq.size() == 8);
      s[9]  = m_txha;
      s[8]  = (tq.size() == 0);
      s[7]  = (rq.size() == 8);
      s[6]  = (rq.size() >= 4);
      s[5]  = (rq.size() == 0);
    end
    s[4] = m_oe;
    s[3] = m_ow;
    s[0] = m_txc;
    return s;
  endfunction

  function automatic bit irq_exp();
    bit md = m_ctrl[0];
    return (m_ctrl[1] && (m_oe || m_ow)) || (m_ctrl[2] && m_txc)
        || (md && m_ctrl[3] && rq.size() >= 4) || (md && m_ctrl[4] && rq.size() == 8)
        || (md && m_ctrl[5] && tq.size() == 0) || (md && m_ctrl[6] && m_txha)
        || (md && m_ctrl[7] && rq.size() != 0);
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      tq.delete(); rq.delete();
      m_txha = 0; m_oe = 0; m_ow = 0; m_txc = 0; m_irq = 0; m_ctrl = 8'h01;
    end else begin
      int tc, rc, tn, rn;
      bit tpush, oe_set, ow_set, txc_set, swr;
      m_irq = irq_exp();
      tc = tq.size(); rc = rq.size();
      tpush = tx_push && tc < 8;
      txc_set = eng_done && tc == 0;
      if (eng_tx_take && tc > 0) void'(tq.pop_front());
      if (tpush) tq.push_back(tx_data);
      tn = tq.size();
      if (tn == 4 && tc != 4) m_txha = 1;
      else if (tpush) m_txha = 0;
      oe_set = eng_rx_valid && rc == 8;
      if (rx_pop && rc > 0) void'(rq.pop_front());
      if (eng_rx_valid && rc < 8) rq.push_back(eng_rx_data);
      rn = rq.size();
      ow_set = (rn == 8 && rc != 8);
      swr = reg_wr && reg_addr;
      m_oe  = oe_set  ? 1'b1 : (swr && !reg_wdata[4]) ? 1'b0 : m_oe;
      m_ow  = ow_set  ? 1'b1 : (swr && !reg_wdata[3]) ? 1'b0 : m_ow;
      m_txc = txc_set ? 1'b1 : (swr && !reg_wdata[0]) ? 1'b0 : m_txc;
      if (reg_wr && !reg_addr) m_ctrl = reg_wdata[7:0];
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (checking) begin
      logic [31:0] e;
      e = stat_exp();
      if (!reg_addr) chk("R10 control readback", reg_rdata, {24'b0, m_ctrl});
      else begin
        if (!m_ctrl[0]) chk("R12 status with mode off", reg_rdata, e);
        chk("R3 tx full", 32'(reg_rdata[10]), 32'(e[10]));
        chk("R4 tx halfway", 32'(reg_rdata[9]), 32'(e[9]));
        chk("R5 empty/full/half", 32'(reg_rdata[8:5]), 32'(e[8:5]));
        chk("R6 overrun error", 32'(reg_rdata[4]), 32'(e[4]));
        chk("R7 overrun warning", 32'(reg_rdata[3]), 32'(e[3]));
        chk("R9 tx complete", 32'(reg_rdata[0]), 32'(e[0]));
        chk("R12 unused bits zero", {reg_rdata[31:11], reg_rdata[2:1]}, 32'd0);
      end
      chk("R11 irq", 32'(irq), 32'(m_irq));
      chk("R2 tx request", 32'(eng_tx_req), 32'(tq.size() != 0));
      if (tq.size() != 0) chk("R2 tx head", 32'(eng_tx_data), 32'(tq[0]));
      if (rq.size() != 0) chk("R2 rx head", 32'(rx_data), 32'(rq[0]));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 1;
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_push = 1; tx_data = d; @(negedge clk); tx_push = 0;
  endtask

  task automatic take_tx();
    eng_tx_take = 1; @(negedge clk); eng_tx_take = 0;
  endtask

  task automatic recv(input logic [7:0] d);
    eng_rx_valid = 1; eng_rx_data = d; @(negedge clk); eng_rx_valid = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    reg_wr = 0; reg_addr = 1; reg_wdata = 0; tx_push = 0; tx_data = 0; rx_pop = 0;
    eng_tx_take = 0; eng_rx_valid = 0; eng_rx_data = 0; eng_done = 0;
    total = 0; fails = 0; checking = 0; finished = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    checking = 1;
    // R1: reset values
    chk("R1 status after reset", reg_rdata, 32'h0000_0120);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    reg_addr = 0; #1;
    chk("R1 control after reset", reg_rdata, 32'h0000_0001);
    reg_addr = 1;
    idle(1);

    // transmit path: fill past full, sticky halfway, drain (R2 R3 R4 R10)
    wr(0, 32'h41);
    for (int i = 0; i < 10; i++) push_tx(8'h10 + 8'(i));
    chk("R3 full after overfill", 32'(reg_rdata[10]), 32'd1);
    for (int i = 0; i < 8; i++) take_tx();
    idle(1);
    chk("R4 halfway sticky when drained", 32'(reg_rdata[9]), 32'd1);
    take_tx();
    eng_done = 1; idle(1); eng_done = 0;
    chk("R9 complete on done with empty queue", 32'(reg_rdata[0]), 32'd1);
    push_tx(8'hA5);
    chk("R4 cleared by push", 32'(reg_rdata[9]), 32'd0);
    take_tx();

    // receive path: overrun and warning, write-one keeps, write-zero clears (R6 R7 R8)
    wr(0, 32'h9B);
    for (int i = 0; i < 10; i++) recv(8'hC0 + 8'(i));
    chk("R6 overrun set", 32'(reg_rdata[4]), 32'd1);
    chk("R7 warning set", 32'(reg_rdata[3]), 32'd1);
    wr(1, 32'hFFFF_FFFF);
    chk("R8 write ones keeps flags", 32'(reg_rdata[4:3]), 32'd3);
    for (int i = 0; i < 3; i++) begin rx_pop = 1; idle(1); rx_pop = 0; end
    wr(1, 32'h0);
    chk("R8 write zeros clears", 32'({reg_rdata[4:3], reg_rdata[0]}), 32'd0);

    // FIFO mode off masks the level flags and their terms (R12)
    wr(0, 32'hF8);
    idle(2);
    chk("R12 level bits masked", 32'(reg_rdata[10:5]), 32'd0);
    chk("R12 irq masked", 32'(irq), 32'd0);
    wr(0, 32'hF9);
    idle(2);
    chk("R10 irq with receive enables", 32'(irq), 32'd1);
    for (int i = 0; i < 5; i++) begin rx_pop = 1; idle(1); rx_pop = 0; end

    // mixed traffic
    for (int c = 0; c < 3000; c++) begin
      tx_push      = ($urandom_range(0, 2) == 0);
      tx_data      = 8'($urandom);
      eng_tx_take  = ($urandom_range(0, 2) == 0);
      eng_rx_valid = ($urandom_range(0, 2) == 0);
      eng_rx_data  = 8'($urandom);
      rx_pop       = ($urandom_range(0, 2) == 0);
      eng_done     = ($urandom_range(0, 5) == 0);
      reg_wr = 0; reg_addr = 1;
      if ($urandom_range(0, 40) == 0) begin reg_wr = 1; reg_addr = 0; reg_wdata = $urandom; end
      else if ($urandom_range(0, 30) == 0) begin reg_wr = 1; reg_wdata = $urandom; end
      else if ($urandom_range(0, 20) == 0) reg_addr = 0;
      idle(1);
    end
    tx_push = 0; eng_tx_take = 0; eng_rx_valid = 0; rx_pop = 0; eng_done = 0;
    reg_wr = 0; reg_addr = 1;
    idle(3);
    summary();
  end
endmodule